// File: doc/BRIEF.md
# Prescaled Multi-Channel Match Timer

A free-running count register advances once every N clock cycles, where N is one more than a programmable prescale limit. A set of match channels compares each of its own stored values against the count. When a channel sees its value, it records a pending flag and applies a programmable action to its own output pin. Each channel can also be configured to restart the count from zero or to halt counting altogether. A level interrupt output is raised while any flag whose channel has interrupt enabled is pending.

Software drives the block through a plain register port. The port is a write strobe with an address and write data, plus read data that follows the address combinationally. The port has no back-pressure: every write strobe is accepted on the clock edge where it is seen. The count always advances on the block's own clock.

The register map, with word addresses, is: 0 flags, 1 control, 2 count, 3 prescale limit, 4 prescale counter, 5 channel configuration, 6 pin register, and 8 upward for the channel match values (channel n at 8+n). Unused addresses read as zero.

Top module: `mtmr_top`

## Requirements
- R1: After reset, every register reads zero, all match pins are low, the interrupt output is low and the count does not move.
- R2: While control bit 0 (enable) is set, the prescale counter (address 4) steps by one each clock. In the clock after it has reached the prescale limit (address 3), it returns to 0 and the count (address 2) steps by one. The count therefore advances once every limit+1 clocks.
- R3: While control bit 1 (clear) is set, both the count and the prescale counter are forced to zero. While enable is clear, both hold their value.
- R4: A channel matches on the first prescale cycle of a count value equal to its match value (address 8+n) while enabled and not cleared. On the following edge it sets flag bit n (address 0, bits 0 to NCH-1). Writing 1 to a flag bit clears it and writing 0 leaves it unchanged.
- R5: The interrupt output is high exactly when some flag bit n is set whose interrupt enable (configuration bit 3n, address 5) is set. A pending flag with its enable clear does not raise it.
- R6: With configuration bit 3n+1 set, a match on channel n makes the count return to 0 at the next count step instead of moving to the match value plus one.
- R7: With configuration bit 3n+2 set, a match on channel n clears the enable bit and freezes the count and prescale counter at their matched values. This halt takes priority over any restart requested in the same cycle.
- R8: Each channel's 2-bit pin action sits at pin-register bits NCH+2n+1:NCH+2n. On a match, code 0 leaves the pin, 1 drives it low, 2 drives it high and 3 inverts it. The action is applied once per match, not on every prescale cycle of the matched count.
- R9: Pin-register bits NCH-1:0 set the match pin levels directly when written, and the whole pin register reads back as written.
- R10: The count, the prescale limit and the prescale counter can be written and read back. A bus write to the count takes priority over counting in the same cycle.
- R11: The count wraps from its all-ones value to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, accepted on the clock edge |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Read data for the register at reg_addr |
| irq | output | 1 | Level interrupt: enabled pending flags |
| match_pin | output | NCH | Per-channel match output pins |

## Verification
The bench builds the block with a 16-bit count, four channels and a 4-bit address. The narrow count brings the wrap from all ones to zero within a few cycles of a preload. It also keeps parked match values safely out of the way of every scenario. Four channels exercise each pin action code at once in a single match event, and they also exercise stop and restart requested by one channel in the same cycle. Small prescale limits of 0, 1 and 2 make each count step and its match, restart and halt timing visible cycle by cycle.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  // Register word addresses
  localparam int unsigned ADR_FLAG  = 0;
  localparam int unsigned ADR_CTRL  = 1;
  localparam int unsigned ADR_COUNT = 2;
  localparam int unsigned ADR_PLIM  = 3;
  localparam int unsigned ADR_PCNT  = 4;
  localparam int unsigned ADR_CFG   = 5;
  localparam int unsigned ADR_PIN   = 6;
  localparam int unsigned ADR_MATCH = 8;

  // Pin action on a match
  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } pin_act_e;
endpackage

// File: rtl/mtmr_prescale.sv
module mtmr_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         go,
  input  logic         wr_lim,
  input  logic         wr_cnt,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         tick
);
  logic wrap;

  // A counter written above the limit also wraps on its next step
  assign wrap = (cnt >= lim);
  assign tick = go & ~hold & ~wr_cnt & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim <= '0;
    end else if (wr_lim) begin
      lim <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (hold) begin
      cnt <= '0;
    end else if (wr_cnt) begin
      cnt <= wdata;
    end else if (go) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mtmr_chan.sv
module mtmr_chan
  import mtmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count,
  input  logic         live,
  input  logic         first,
  input  logic         wr_val,
  input  logic [W-1:0] wdata,
  input  logic         wr_pin,
  input  logic         lvl_in,
  input  logic [1:0]   act_in,
  input  logic         clr_flag,
  output logic         eq,
  output logic         hit,
  output logic [W-1:0] val,
  output logic         flag,
  output logic         pin,
  output logic [1:0]   act
);
  assign eq  = (count == val);
  assign hit = live & first & eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
    end else if (wr_val) begin
      val <= wdata;
    end
  end

  // A new match wins over a clearing write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (hit) begin
      flag <= 1'b1;
    end else if (clr_flag) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 2'd0;
    end else if (wr_pin) begin
      act <= act_in;
    end
  end

  // A direct level write wins over a match action in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin <= 1'b0;
    end else if (wr_pin) begin
      pin <= lvl_in;
    end else if (hit) begin
      case (pin_act_e'(act))
        ACT_LOW:  pin <= 1'b0;
        ACT_HIGH: pin <= 1'b1;
        ACT_FLIP: pin <= ~pin;
        default:  pin <= pin;
      endcase
    end
  end
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
  import mtmr_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [W-1:0]   reg_wdata,
  output logic [W-1:0]   reg_rdata,
  output logic           irq,
  output logic [NCH-1:0] match_pin
);
  localparam int CFGW = 3 * NCH;
  localparam int PINW = 3 * NCH;

  logic            ctrl_en, ctrl_hold;
  logic [W-1:0]    tc;
  logic [W-1:0]    pc_q, pr_q;
  logic            tick, go, live, first, stop_hit, rst_req;
  logic [CFGW-1:0] cfg_q;
  logic [NCH-1:0]  int_en, rst_en, stop_en;
  logic [NCH-1:0]  eq, hit, flag, pin, wr_val;
  logic [W-1:0]    mr_val [NCH];
  logic [1:0]      act_q  [NCH];
  logic [PINW-1:0] pin_reg_q;

  logic sel_flag, sel_ctrl, sel_count, sel_plim, sel_pcnt, sel_cfg, sel_pin;
  assign sel_flag  = reg_wr && (reg_addr == AW'(ADR_FLAG));
  assign sel_ctrl  = reg_wr && (reg_addr == AW'(ADR_CTRL));
  assign sel_count = reg_wr && (reg_addr == AW'(ADR_COUNT));
  assign sel_plim  = reg_wr && (reg_addr == AW'(ADR_PLIM));
  assign sel_pcnt  = reg_wr && (reg_addr == AW'(ADR_PCNT));
  assign sel_cfg   = reg_wr && (reg_addr == AW'(ADR_CFG));
  assign sel_pin   = reg_wr && (reg_addr == AW'(ADR_PIN));

  assign live     = ctrl_en & ~ctrl_hold;
  assign first    = (pc_q == '0);
  assign stop_hit = |(hit & stop_en);
  assign rst_req  = |(eq & rst_en);
  assign go       = live & ~stop_hit;

  mtmr_prescale #(.W(W)) u_prescale (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (ctrl_hold),
    .go     (go),
    .wr_lim (sel_plim),
    .wr_cnt (sel_pcnt),
    .wdata  (reg_wdata),
    .lim    (pr_q),
    .cnt    (pc_q),
    .tick   (tick)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign int_en[n] = cfg_q[3*n];
    assign rst_en[n] = cfg_q[3*n+1];
    assign stop_en[n] = cfg_q[3*n+2];
    assign wr_val[n] = reg_wr && (reg_addr == AW'(ADR_MATCH + n));
    assign pin_reg_q[n] = pin[n];
    assign pin_reg_q[NCH+2*n +: 2] = act_q[n];

    mtmr_chan #(.W(W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (tc),
      .live     (live),
      .first    (first),
      .wr_val   (wr_val[n]),
      .wdata    (reg_wdata),
      .wr_pin   (sel_pin),
      .lvl_in   (reg_wdata[n]),
      .act_in   (reg_wdata[NCH+2*n +: 2]),
      .clr_flag (sel_flag & reg_wdata[n]),
      .eq       (eq[n]),
      .hit      (hit[n]),
      .val      (mr_val[n]),
      .flag     (flag[n]),
      .pin      (pin[n]),
      .act      (act_q[n])
    );
  end

  // Control: a stop request from a channel beats a software enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_hold <= 1'b0;
    end else begin
      if (sel_ctrl) begin
        ctrl_en   <= reg_wdata[0];
        ctrl_hold <= reg_wdata[1];
      end
      if (stop_hit) begin
        ctrl_en <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (sel_cfg) begin
      cfg_q <= reg_wdata[CFGW-1:0];
    end
  end

  // Main count: clear, then bus write, then step or restart
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc <= '0;
    end else if (ctrl_hold) begin
      tc <= '0;
    end else if (sel_count) begin
      tc <= reg_wdata;
    end else if (tick) begin
      tc <= rst_req ? '0 : tc + 1'b1;
    end
  end

  assign irq       = |(flag & int_en);
  assign match_pin = pin;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(ADR_FLAG))       reg_rdata = W'(flag);
    else if (reg_addr == AW'(ADR_CTRL))  reg_rdata = W'({ctrl_hold, ctrl_en});
    else if (reg_addr == AW'(ADR_COUNT)) reg_rdata = tc;
    else if (reg_addr == AW'(ADR_PLIM))  reg_rdata = pr_q;
    else if (reg_addr == AW'(ADR_PCNT))  reg_rdata = pc_q;
    else if (reg_addr == AW'(ADR_CFG))   reg_rdata = W'(cfg_q);
    else if (reg_addr == AW'(ADR_PIN))   reg_rdata = W'(pin_reg_q);
    else begin
      for (int n = 0; n < NCH; n++) begin
        if (reg_addr == AW'(ADR_MATCH + n)) reg_rdata = mr_val[n];
      end
    end
  end
endmodule

// File: rtl/mtmr_checks.sv
module mtmr_checks #(
  parameter int W   = 32,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [AW-1:0]  reg_addr,
  input logic [NCH-1:0] clr_bits,
  input logic           irq,
  input logic           ctrl_en,
  input logic           ctrl_hold,
  input logic [W-1:0]   tc,
  input logic [W-1:0]   pc,
  input logic [W-1:0]   pr,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] hits,
  input logic           stop_hit,
  input logic           rst_req,
  input logic           tick,
  input logic           go
);
  assert_prescale_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !reg_wr && (pc < pr)) |=> ((pc == $past(pc) + 1'b1) && $stable(tc)));

  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hold |=> ((tc == '0) && (pc == '0)));

  assert_idle_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !ctrl_hold && !reg_wr) |=> ($stable(tc) && $stable(pc)));

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hits != '0) |=> ((flags & $past(hits)) == $past(hits)));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == '0) && (hits == '0)) |=> ((flags & $past(clr_bits)) == '0));

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));

  assert_match_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rst_req && !reg_wr) |=> (tc == '0));

  assert_stop_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && !reg_wr) |=> (!ctrl_en && $stable(tc) && $stable(pc)));
endmodule

bind mtmr_top mtmr_checks #(.W(W), .NCH(NCH), .AW(AW)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .clr_bits  (reg_wdata[NCH-1:0]),
  .irq       (irq),
  .ctrl_en   (ctrl_en),
  .ctrl_hold (ctrl_hold),
  .tc        (tc),
  .pc        (pc_q),
  .pr        (pr_q),
  .flags     (flag),
  .hits      (hit),
  .stop_hit  (stop_hit),
  .rst_req   (rst_req),
  .tick      (tick),
  .go        (go)
);

// File: tb/mtmr_top_test.sv
module mtmr_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int NCH = 4;
  localparam int AW  = 4;

  localparam int A_FLAG = 0, A_CTRL = 1, A_COUNT = 2, A_PLIM = 3;
  localparam int A_PCNT = 4, A_CFG = 5, A_PIN = 6, A_MATCH = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [W-1:0]   reg_wdata = '0;
  logic [W-1:0]   reg_rdata;
  logic           irq;
  logic [NCH-1:0] match_pin;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtmr_top #(.W(W), .NCH(NCH), .AW(AW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .match_pin (match_pin)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge
  task automatic wr(input int a, input logic [W-1:0] d);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] v);
    reg_addr = AW'(a);
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic clean();
    wr(A_CTRL, 16'h2);
    wr(A_CTRL, 16'h0);
    wr(A_CFG, 16'h0);
    wr(A_PIN, 16'h0);
    wr(A_FLAG, 16'hF);
    for (int n = 0; n < NCH; n++) wr(A_MATCH + n, 16'h7FFF);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    for (int a = 0; a < 12; a++) begin
      rd(a, v);
      check("R1 register reset", v, 0);
    end
    check("R1 pins reset", match_pin, 0);
    check("R1 irq reset", irq, 0);
    wait_cyc(3);
    rd(A_COUNT, v);
    check("R1 count idle", v, 0);
  endtask

  task automatic t_prescale();
    logic [W-1:0] v;
    clean();
    wr(A_PLIM, 16'd2);
    wr(A_CTRL, 16'h1);
    wait_cyc(3);
    rd(A_COUNT, v); check("R2 count after 3 clocks", v, 1);
    rd(A_PCNT, v);  check("R2 prescale wrapped", v, 0);
    wait_cyc(2);
    rd(A_PCNT, v);  check("R2 prescale at limit", v, 2);
    rd(A_COUNT, v); check("R2 count holds within period", v, 1);
    wr(A_CTRL, 16'h0);
    wait_cyc(3);
    rd(A_COUNT, v); check("R3 disabled count frozen", v, 2);
    rd(A_PCNT, v);  check("R3 disabled prescale frozen", v, 0);
  endtask

  task automatic t_clear();
    logic [W-1:0] v;
    wr(A_CTRL, 16'h3);
    wait_cyc(3);
    rd(A_COUNT, v); check("R3 clear holds count", v, 0);
    rd(A_PCNT, v);  check("R3 clear holds prescale", v, 0);
    wr(A_CTRL, 16'h1);
    wait_cyc(3);
    rd(A_COUNT, v); check("R3 count resumes after clear", v, 1);
  endtask

  task automatic t_flag_toggle();
    logic [W-1:0] v;
    clean();
    wr(A_PLIM, 16'd0);
    wr(A_MATCH + 0, 16'd3);
    wr(A_CFG, 16'h1);
    wr(A_PIN, 16'h30);
    check("R8 toggle pin start", match_pin, 4'b0000);
    wr(A_CTRL, 16'h1);
    wait_cyc(3);
    rd(A_FLAG, v); check("R4 no flag before match edge", v, 0);
    check("R5 irq low before match", irq, 0);
    wait_cyc(1);
    rd(A_FLAG, v); check("R4 flag set on match", v, 1);
    check("R5 irq raised", irq, 1);
    check("R8 toggle applied", match_pin, 4'b0001);
    wait_cyc(4);
    check("R8 toggle applied once", match_pin, 4'b0001);
    wr(A_FLAG, 16'h0);
    rd(A_FLAG, v); check("R4 write zero keeps flag", v, 1);
    wr(A_FLAG, 16'h1);
    rd(A_FLAG, v); check("R4 write one clears flag", v, 0);
    check("R5 irq drops after clear", irq, 0);
  endtask

  task automatic t_irq_mask();
    logic [W-1:0] v;
    clean();
    wr(A_PLIM, 16'd0);
    wr(A_MATCH + 1, 16'd2);
    wr(A_CTRL, 16'h1);
    wait_cyc(4);
    rd(A_FLAG, v); check("R4 channel 1 flag", v, 2);
    check("R5 masked flag keeps irq low", irq, 0);
    wr(A_CFG, 16'h8);
    check("R5 enabling raises irq", irq, 1);
  endtask

  task automatic t_restart();
    logic [W-1:0] v;
    clean();
    wr(A_PLIM, 16'd1);
    wr(A_MATCH + 2, 16'd2);
    wr(A_CFG, 16'h80);
    wr(A_CTRL, 16'h1);
    wait_cyc(5);
    rd(A_COUNT, v); check("R6 count at match value", v, 2);
    rd(A_PCNT, v);  check("R6 prescale before step", v, 1);
    wait_cyc(1);
    rd(A_COUNT, v); check("R6 count restarted", v, 0);
    wait_cyc(2);
    rd(A_COUNT, v); check("R6 count after restart", v, 1);
    rd(A_FLAG, v);  check("R6 channel 2 flag", v, 4);
  endtask

  task automatic t_stop();
    logic [W-1:0] v;
    clean();
    wr(A_PLIM, 16'd1);
    wr(A_MATCH + 3, 16'd3);
    wr(A_CFG, 16'hC00);
    wr(A_CTRL, 16'h1);
    wait_cyc(10);
    rd(A_COUNT, v); check("R7 count frozen at match", v, 3);
    rd(A_PCNT, v);  check("R7 prescale frozen", v, 0);
    rd(A_CTRL, v);  check("R7 enable cleared", v, 0);
    rd(A_FLAG, v);  check("R7 channel 3 flag", v, 8);
  endtask

  task automatic t_pins();
    logic [W-1:0] v;
    clean();
    wr(A_PLIM, 16'd0);
    for (int n = 0; n < NCH; n++) wr(A_MATCH + n, 16'd1);
    wr(A_PIN, 16'hC66);
    check("R9 direct pin levels", match_pin, 4'b0110);
    rd(A_PIN, v); check("R9 pin register readback", v, 16'hC66);
    wr(A_CTRL, 16'h1);
    wait_cyc(1);
    check("R8 pins unchanged before match edge", match_pin, 4'b0110);
    wait_cyc(1);
    check("R8 high/low/keep/invert", match_pin, 4'b1101);
    wait_cyc(3);
    check("R8 pins stable after match", match_pin, 4'b1101);
  endtask

  task automatic t_bus();
    logic [W-1:0] v;
    clean();
    wr(A_COUNT, 16'h1234);
    rd(A_COUNT, v); check("R10 count readback", v, 16'h1234);
    wr(A_PLIM, 16'd5);
    rd(A_PLIM, v);  check("R10 limit readback", v, 5);
    wr(A_PCNT, 16'd3);
    rd(A_PCNT, v);  check("R10 prescale readback", v, 3);
    wr(A_PLIM, 16'd0);
    wr(A_CTRL, 16'h1);
    wr(A_COUNT, 16'd100);
    rd(A_COUNT, v); check("R10 bus write beats counting", v, 100);
    wait_cyc(1);
    rd(A_COUNT, v); check("R10 count steps after write", v, 101);
  endtask

  task automatic t_wrap();
    logic [W-1:0] v;
    clean();
    wr(A_PLIM, 16'd0);
    wr(A_COUNT, 16'hFFFE);
    wr(A_CTRL, 16'h1);
    rd(A_COUNT, v); check("R11 preload", v, 16'hFFFE);
    wait_cyc(1);
    rd(A_COUNT, v); check("R11 all ones", v, 16'hFFFF);
    wait_cyc(1);
    rd(A_COUNT, v); check("R11 wrap to zero", v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_clear();
    t_flag_toggle();
    t_irq_mask();
    t_restart();
    t_stop();
    t_pins();
    t_bus();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule